// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides the power state of one CPU subsystem. When the CPU issues a sleep request strobe (wait-for-interrupt or wait-for-event style), it combines the CPU's deep-sleep indication with a power-down select bit. The result is one of three states. SLEEP gates only the CPU clock. STOP halts every clock and keeps the regulator running. STANDBY switches off the core supply, the voltage detector and the core domain. Each low-power state listens to its own class of wake sources and ignores the others.

Leaving STOP resumes execution at once. Leaving STANDBY first passes through a boot phase of `BOOT_CYCLES` cycles that models the core reset. After that the block reads RUN with a standby-exit flag raised. On either exit the block pulses a request that forces the system clock back to the internal RC oscillator.

A wait-for-event request meets an event that is already pending in one case: the request is absorbed, the event is consumed, and the CPU keeps running.

The FSM states are RUN, SLEEP, STOP, STANDBY and BOOT. The transitions are:
- RUN→SLEEP: request with deep-sleep clear.
- RUN→STOP: request with deep-sleep set and power-down select clear.
- RUN→STANDBY: request with both set.
- RUN→RUN: WFE request with a pending event, which consumes the event.
- SLEEP→RUN: interrupt wake, or event wake when SLEEP was entered by WFE.
- STOP→RUN: external-line wake.
- STANDBY→BOOT: standby-class wake.
- BOOT→RUN: boot count expired.

Top module: `lpm_seq`

## Requirements
- R1: After reset the mode code is 00 (RUN), all five enables are 1, and the standby-exit flag and the clock-to-RC pulse are 0.
- R2: A request accepted in RUN moves the mode code on the next cycle, chosen as follows:
  - deep-sleep 0 gives 01 (SLEEP);
  - deep-sleep 1 with power-down select 0 gives 10 (STOP);
  - both 1 give 11 (STANDBY).
- R3: In SLEEP the CPU clock enable is 0, and the system clock, regulator, core power and voltage detector enables are 1.
- R4: In STOP both clock enables are 0, and the regulator, core power and voltage detector enables stay 1.
- R5: In STANDBY all five enables are 0.
- R6: SLEEP returns to RUN one cycle after any `irq_wake` bit is high. An `evt_in` pulse also wakes SLEEP, but only if SLEEP was entered by a WFE request; after a WFI entry it is ignored. `exti_wake` and `stby_wake` do not wake SLEEP.
- R7: STOP returns to RUN one cycle after any `exti_wake` bit is high. `irq_wake`, `stby_wake` and `evt_in` do not wake STOP.
- R8: STANDBY wakes only on a `stby_wake` bit; the other wake inputs are ignored. After the wake, the mode code stays 11 for `BOOT_CYCLES` cycles, with regulator and core power at 1 and clocks and voltage detector at 0. The block then enters RUN.
- R9: `clk_to_rc` is high for exactly the first RUN cycle after STOP or after the boot phase. It is never high after a SLEEP exit.
- R10: `stby_exit` rises together with the first RUN cycle after the boot phase and stays high until the next accepted low-power entry.
- R11: An `evt_in` pulse seen in RUN makes an event pending. A WFE request while an event is pending leaves the mode at RUN and consumes the event, so the next WFE request enters its state. WFI requests neither consume the event nor are blocked by it.
- R12: `sleep_req` is ignored outside RUN, and wake inputs are ignored in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep request strobe from the CPU |
| req_wfe | input | 1 | 1: request is wait-for-event style, 0: wait-for-interrupt |
| cpu_deep | input | 1 | CPU deep-sleep indication |
| pd_sel | input | 1 | Power-down select: 1 picks STANDBY over STOP |
| evt_in | input | 1 | Event strobe |
| irq_wake | input | N_IRQ | Enabled peripheral interrupt lines |
| exti_wake | input | N_EXTI | Enabled external-interrupt lines (interrupt or event mode) |
| stby_wake | input | N_STBY | Standby-class wake sources (wake pin edge, RTC, tamper, timestamp, reset causes) |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| reg_en | output | 1 | Core regulator enable |
| core_pwr_en | output | 1 | Core domain power enable |
| vdet_en | output | 1 | Supply voltage detector enable |
| clk_to_rc | output | 1 | One-cycle pulse forcing the system clock to the internal RC oscillator |
| stby_exit | output | 1 | Set after a standby exit |
| mode | output | 2 | 00 RUN, 01 SLEEP, 10 STOP, 11 STANDBY |

## Verification
The state is registered and every output decodes from it. A request or wake input held across a rising edge is therefore visible on `mode` and the enables right after that edge, which is one cycle later. `clk_to_rc` and `stby_exit` come from their own registers that load on the same edge, so they are due in the same cycle as the mode change. After a standby wake, the boot phase adds `BOOT_CYCLES` cycles with mode 11 before RUN appears.

The bench steps a cycle-accurate reference model on every edge and compares all outputs one time unit after the edge. Directed sequences and random stimulus therefore share the same timing.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        S_RUN     = 3'd0,
        S_SLEEP   = 3'd1,
        S_STOP    = 3'd2,
        S_STANDBY = 3'd3,
        S_BOOT    = 3'd4
    } lpm_state_e;

    localparam logic [1:0] MODE_RUN     = 2'b00;
    localparam logic [1:0] MODE_SLEEP   = 2'b01;
    localparam logic [1:0] MODE_STOP    = 2'b10;
    localparam logic [1:0] MODE_STANDBY = 2'b11;

    typedef struct packed {
        logic cpu_clk;
        logic sys_clk;
        logic reg_on;
        logic core_pwr;
        logic vdet;
    } lpm_enables_t;

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int N_IRQ  = 4,
    parameter int N_EXTI = 4,
    parameter int N_STBY = 6
) (
    input  lpm_state_e        state,
    input  logic              wfe_entry,
    input  logic              evt_in,
    input  logic [N_IRQ-1:0]  irq_wake,
    input  logic [N_EXTI-1:0] exti_wake,
    input  logic [N_STBY-1:0] stby_wake,
    output logic              wake
);

    logic any_irq, any_exti, any_stby;

    assign any_irq  = |irq_wake;
    assign any_exti = |exti_wake;
    assign any_stby = |stby_wake;

    // Each low-power state listens only to its own class of source.
    always_comb begin
        wake = 1'b0;
        unique case (state)
            S_SLEEP:   wake = any_irq || (wfe_entry && evt_in);
            S_STOP:    wake = any_exti;
            S_STANDBY: wake = any_stby;
            default:   wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpm_boot_timer.sv
module lpm_boot_timer #(
    parameter int BOOT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);

    localparam int CW = (BOOT_CYCLES < 2) ? 1 : $clog2(BOOT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(BOOT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign done = active && (cnt == LAST);

    // R8
    boot_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= LAST));

    // R8
    boot_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0));

endmodule

// File: rtl/lpm_pwr_decode.sv
module lpm_pwr_decode
    import lpm_pkg::*;
(
    input  lpm_state_e   state,
    output lpm_enables_t en,
    output logic [1:0]   mode_code
);

    always_comb begin
        en        = '{cpu_clk: 1'b1, sys_clk: 1'b1, reg_on: 1'b1, core_pwr: 1'b1, vdet: 1'b1};
        mode_code = MODE_RUN;
        unique case (state)
            S_RUN: begin
                mode_code = MODE_RUN;
            end
            S_SLEEP: begin
                en.cpu_clk = 1'b0;
                mode_code  = MODE_SLEEP;
            end
            S_STOP: begin
                en.cpu_clk = 1'b0;
                en.sys_clk = 1'b0;
                mode_code  = MODE_STOP;
            end
            S_STANDBY: begin
                en        = '0;
                mode_code = MODE_STANDBY;
            end
            S_BOOT: begin
                en        = '{cpu_clk: 1'b0, sys_clk: 1'b0, reg_on: 1'b1, core_pwr: 1'b1, vdet: 1'b0};
                mode_code = MODE_STANDBY;
            end
            default: begin
                en        = '0;
                mode_code = MODE_STANDBY;
            end
        endcase
    end

    always_comb begin
        // R3
        cpu_needs_sys_chk: assert (!en.cpu_clk || en.sys_clk);
        // R5
        core_needs_reg_chk: assert (!en.core_pwr || en.reg_on);
    end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int N_EXTI      = 4,
    parameter int N_STBY      = 6,
    parameter int BOOT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              req_wfe,
    input  logic              cpu_deep,
    input  logic              pd_sel,
    input  logic              evt_in,
    input  logic [N_IRQ-1:0]  irq_wake,
    input  logic [N_EXTI-1:0] exti_wake,
    input  logic [N_STBY-1:0] stby_wake,
    output logic              cpu_clk_en,
    output logic              sys_clk_en,
    output logic              reg_en,
    output logic              core_pwr_en,
    output logic              vdet_en,
    output logic              clk_to_rc,
    output logic              stby_exit,
    output logic [1:0]        mode
);

    lpm_state_e   st, nxt;
    lpm_enables_t en;
    logic         wake, boot_done;
    logic         evt_pend, wfe_entry;
    logic         absorb, entering;

    lpm_wake_qual #(
        .N_IRQ (N_IRQ),
        .N_EXTI(N_EXTI),
        .N_STBY(N_STBY)
    ) u_wake (
        .state    (st),
        .wfe_entry(wfe_entry),
        .evt_in   (evt_in),
        .irq_wake (irq_wake),
        .exti_wake(exti_wake),
        .stby_wake(stby_wake),
        .wake     (wake)
    );

    lpm_boot_timer #(
        .BOOT_CYCLES(BOOT_CYCLES)
    ) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .active(st == S_BOOT),
        .done  (boot_done)
    );

    lpm_pwr_decode u_dec (
        .state    (st),
        .en       (en),
        .mode_code(mode)
    );

    // A WFE request with an event already pending is absorbed.
    assign absorb   = (st == S_RUN) && sleep_req && req_wfe && evt_pend;
    assign entering = (st == S_RUN) && sleep_req && !absorb;

    always_comb begin
        nxt = st;
        unique case (st)
            S_RUN: begin
                if (entering) begin
                    if (!cpu_deep)   nxt = S_SLEEP;
                    else if (pd_sel) nxt = S_STANDBY;
                    else             nxt = S_STOP;
                end
            end
            S_SLEEP:   if (wake) nxt = S_RUN;
            S_STOP:    if (wake) nxt = S_RUN;
            S_STANDBY: if (wake) nxt = S_BOOT;
            S_BOOT:    if (boot_done) nxt = S_RUN;
            default:   nxt = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_RUN;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_pend  <= 1'b0;
            wfe_entry <= 1'b0;
            stby_exit <= 1'b0;
            clk_to_rc <= 1'b0;
        end else begin
            if (st == S_STANDBY || st == S_BOOT)
                evt_pend <= 1'b0;
            else if (st == S_RUN)
                evt_pend <= (evt_pend && !absorb) || evt_in;

            if (entering)
                wfe_entry <= req_wfe;

            if (st == S_BOOT && boot_done)
                stby_exit <= 1'b1;
            else if (entering)
                stby_exit <= 1'b0;

            clk_to_rc <= (st == S_STOP && wake) || (st == S_BOOT && boot_done);
        end
    end

    assign cpu_clk_en  = en.cpu_clk;
    assign sys_clk_en  = en.sys_clk;
    assign reg_en      = en.reg_on;
    assign core_pwr_en = en.core_pwr;
    assign vdet_en     = en.vdet;

    // R2
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && !stby_exit && sleep_req && !req_wfe && cpu_deep && !pd_sel)
        |=> (mode == MODE_STOP));

    // R9
    rc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_to_rc |=> !clk_to_rc);

    // R9
    rc_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_to_rc |-> (mode == MODE_RUN));

    // R10
    flag_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stby_exit |-> (mode == MODE_RUN));

    // R8
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STANDBY && stby_wake == '0) |=> (st == S_STANDBY));

    // R12
    sleep_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STOP && exti_wake == '0) |=> $stable(mode));

endmodule

// File: tb/tb_lpm_seq.sv
`timescale 1ns/100ps
module tb_lpm_seq;

    localparam int NI = 4, NE = 4, NS = 6, BC = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 0, req_wfe = 0, cpu_deep = 0, pd_sel = 0, evt_in = 0;
    logic [NI-1:0] irq_wake = '0;
    logic [NE-1:0] exti_wake = '0;
    logic [NS-1:0] stby_wake = '0;
    logic cpu_clk_en, sys_clk_en, reg_en, core_pwr_en, vdet_en, clk_to_rc, stby_exit;
    logic [1:0] mode;

    int total = 0, bad = 0;
    // reference model: 0 RUN 1 SLEEP 2 STOP 3 STANDBY 4 BOOT
    int ms = 0, mcnt = 0;
    bit mpend = 0, mwfe = 0, mflag = 0, mrc = 0;

    always #2.5 clk = ~clk;

    lpm_seq #(.N_IRQ(NI), .N_EXTI(NE), .N_STBY(NS), .BOOT_CYCLES(BC)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .req_wfe(req_wfe),
        .cpu_deep(cpu_deep), .pd_sel(pd_sel), .evt_in(evt_in),
        .irq_wake(irq_wake), .exti_wake(exti_wake), .stby_wake(stby_wake),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .reg_en(reg_en),
        .core_pwr_en(core_pwr_en), .vdet_en(vdet_en), .clk_to_rc(clk_to_rc),
        .stby_exit(stby_exit), .mode(mode));

    function automatic logic [1:0] exp_mode(int s);
        return (s == 4) ? 2'b11 : 2'(s);
    endfunction

    // {cpu, sys, reg, core, vdet}
    function automatic logic [4:0] exp_en(int s);
        case (s)
            0: return 5'b11111;
            1: return 5'b01111;
            2: return 5'b00111;
            3: return 5'b00000;
            default: return 5'b00110;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        chk({tag, " mode"}, 8'(mode), 8'(exp_mode(ms)));
        chk({tag, " enables"}, 8'({cpu_clk_en, sys_clk_en, reg_en, core_pwr_en, vdet_en}), 8'(exp_en(ms)));
        chk({tag, " flag/rc"}, 8'({stby_exit, clk_to_rc}), 8'({mflag, mrc}));
    endtask

    // advance one clock with the currently driven inputs, model in lockstep
    task automatic step(string tag);
        int  ns = ms, nc = mcnt;
        bit  np = mpend, nw = mwfe, nf = mflag, nr = 0;
        bit  absorb = (ms == 0) && sleep_req && req_wfe && mpend;
        bit  enter  = (ms == 0) && sleep_req && !absorb;
        case (ms)
            0: if (enter) begin
                   ns = !cpu_deep ? 1 : (pd_sel ? 3 : 2);
                   nw = req_wfe; nf = 0;
               end
            1: if ((|irq_wake) || (mwfe && evt_in)) ns = 0;
            2: if (|exti_wake) begin ns = 0; nr = 1; end
            3: if (|stby_wake) begin ns = 4; nc = 0; end
            default: if (mcnt == BC - 1) begin ns = 0; nf = 1; nr = 1; nc = 0; end
                     else nc = mcnt + 1;
        endcase
        if (ms == 3 || ms == 4) np = 0;
        else if (ms == 0) np = (mpend && !absorb) || evt_in;
        @(posedge clk);
        #1;
        ms = ns; mcnt = nc; mpend = np; mwfe = nw; mflag = nf; mrc = nr;
        compare(tag);
    endtask

    task automatic idle();
        sleep_req = 0; req_wfe = 0; evt_in = 0;
        irq_wake = '0; exti_wake = '0; stby_wake = '0;
    endtask

    task automatic req(bit wfe, bit deep, bit pd, string tag);
        sleep_req = 1; req_wfe = wfe; cpu_deep = deep; pd_sel = pd;
        step(tag);
        idle();
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        compare("R1 reset");

        // R2 / R3 / R6: WFI sleep, exti and stby ignored, irq wakes
        req(0, 0, 0, "R2 sleep entry");
        exti_wake = 4'b0100; stby_wake = 6'b000001; step("R6 other sources ignored"); idle();
        evt_in = 1; step("R6 event ignored after WFI"); idle();
        sleep_req = 1; step("R12 request ignored in SLEEP"); idle();
        irq_wake = 4'b1000; step("R6 irq wake"); idle();
        step("R9 no rc pulse after sleep");

        // R6 WFE entry, event wakes
        req(1, 0, 0, "R3 sleep by WFE");
        evt_in = 1; step("R6 event wake"); idle();

        // R4 / R7: STOP
        req(0, 1, 0, "R2 stop entry");
        irq_wake = 4'b1111; evt_in = 1; stby_wake = 6'b111111; step("R7 irq ignored in STOP"); idle();
        step("R4 stop hold");
        exti_wake = 4'b0001; step("R7 exti wake"); idle();
        step("R9 rc pulse done");

        // R5 / R8 / R10: STANDBY and boot
        req(1, 1, 1, "R2 standby entry");
        irq_wake = 4'b1111; exti_wake = 4'b1111; step("R8 others ignored in STANDBY"); idle();
        step("R5 standby hold");
        stby_wake = 6'b100000; step("R8 standby wake"); idle();
        repeat (BC) step("R8 boot phase");
        step("R10 flag held");
        irq_wake = 4'b0010; step("R12 wake ignored in RUN"); idle();
        req(0, 0, 0, "R10 flag cleared on entry");
        irq_wake = 4'b0001; step("R6 wake"); idle();

        // R11: pending event absorbs WFE
        evt_in = 1; step("R11 event pend"); idle();
        req(0, 0, 0, "R11 WFI not blocked");
        irq_wake = 4'b0001; step("R11 wake"); idle();
        req(1, 1, 0, "R11 WFE absorbed");
        req(1, 1, 0, "R11 second WFE enters");
        exti_wake = 4'b1000; step("R7 wake"); idle();

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            sleep_req = ($urandom_range(0, 9) == 0);
            req_wfe   = $urandom_range(0, 1);
            cpu_deep  = $urandom_range(0, 1);
            pd_sel    = ($urandom_range(0, 2) == 0);
            evt_in    = ($urandom_range(0, 7) == 0);
            irq_wake  = ($urandom_range(0, 5) == 0) ? NI'($urandom) : '0;
            exti_wake = ($urandom_range(0, 5) == 0) ? NE'($urandom) : '0;
            stby_wake = ($urandom_range(0, 7) == 0) ? NS'($urandom) : '0;
            step("R12 random");
        end
        idle();
        step("R12 random end");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule